// File: doc/BRIEF.md
# DDR Mode-Write Command Decoder

This block sits on the device side of a double-data-rate SDRAM command bus. While the clock enable is high, it samples the active-low select and strobe lines, the two bank-select bits and the address bus on every rising clock edge. It classifies the command it sees. When the command is a mode write, it updates one of two configuration registers. The main register holds burst length, burst ordering and read latency. The extended register holds DLL enable and output drive strength. The decoded fields leave the block as ready-to-use values, so the data path and strobe generators can read them directly.

A mode write is checked before it is accepted. A reserved code point, a nonzero bit in a must-be-zero position, or any open bank rejects it. A rejected write raises a one-cycle error pulse and changes nothing. An accepted write starts a one-cycle busy window, and a command that arrives during that window is not acted on. An accepted main-register write with the DLL-reset bit set also gives a one-cycle DLL-reset pulse.

Top module: `ddr_mode_decoder`

## Requirements
- R1: After reset the outputs are: burst length 2, sequential ordering, read latency 3, DLL enabled, drive code 00, command code 0, and no error, busy or DLL-reset pulse.
- R2: With CKE high and CS low, {RAS,CAS,WE} decodes on the next edge to cmd_o as follows: 111 NOP=1, 011 activate=2, 101 read=3, 100 write=4, 010 precharge=5, 001 refresh=6, 000 mode write=7, 110 burst stop=8. With CS high or CKE low, cmd_o is 0 and nothing else changes.
- R3: A mode write with BA=00 sets the burst length from A2..A0: 001 gives 2, 010 gives 4, 011 gives 8. A3 sets the ordering: 0 is sequential, 1 is interleaved. The new values appear after the sampling edge.
- R4: In the same write, A6..A4 sets the read latency: 011 gives 3, 100 gives 4, 101 gives 5.
- R5: A mode write with BA=01 writes the extended register. A0=0 enables the DLL and A0=1 disables it. drive_o takes {A6,A1}.
- R6: A mode write is rejected if any of these holds: a reserved length or latency code; A7, A11..A9 or BA1 set in a BA0=0 write; A5..A2, A11..A7 or BA1 set in a BA0=1 write. A rejection gives mode_err_o high for one cycle, no register change and no busy.
- R7: A mode write while any bit of bank_open_i is set is rejected in the same way.
- R8: An accepted BA=00 write with A8=1 gives dll_reset_o high for exactly one cycle, and the register takes the new values on that same edge.
- R9: An accepted mode write sets busy_o for the following cycle. A command with CS low sampled during busy is reported as code 9 and has no effect, even if it is a mode write.
- R10: A mode write pattern with CS high leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs sampled on rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Clock enable; low means no command is sampled |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select; BA0 picks the main or extended register |
| addr_i | input | ADDR_W | Address bus carrying the mode fields |
| bank_open_i | input | BANKS | One bit per bank, high while the row is open |
| cmd_o | output | 4 | Code of the command sampled at the last edge |
| burst_len_o | output | 4 | Burst length value (2, 4 or 8) |
| burst_il_o | output | 1 | 1 means interleaved ordering |
| read_lat_o | output | 3 | Read latency in clocks |
| dll_reset_o | output | 1 | One-cycle DLL reset pulse |
| dll_on_o | output | 1 | DLL enable |
| drive_o | output | 2 | Output drive strength code |
| mode_err_o | output | 1 | One-cycle pulse for a rejected mode write |
| busy_o | output | 1 | High in the cycle after an accepted mode write |

## Verification
The hardest case to reach is the busy window: it lasts one cycle and opens only after an accepted write. The stimulus therefore puts a second mode write, or another command, on the very next edge after a legal write. The blocked write carries field values that differ from the stored ones, so a register that was wrongly updated shows at the outputs. The stimulus also places rejected writes back to back and follows a rejection with an immediate legal write. This shows that a rejection opens no busy window.

// File: rtl/ddr_mode_pkg.sv
package ddr_mode_pkg;
  typedef enum logic [3:0] {
    CMD_NONE  = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_WR    = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_REF   = 4'd6,
    CMD_MODE  = 4'd7,
    CMD_BST   = 4'd8,
    CMD_BLOCK = 4'd9
  } cmd_e;

  localparam int BL_LSB  = 0;
  localparam int BL_W    = 3;
  localparam int IL_BIT  = 3;
  localparam int CL_LSB  = 4;
  localparam int CL_W    = 3;
  localparam int TM_BIT  = 7;
  localparam int DR_BIT  = 8;
  localparam int DLL_BIT = 0;
  localparam int DS0_BIT = 1;
  localparam int DS1_BIT = 6;
endpackage

// File: rtl/ddr_cmd_classify.sv
module ddr_cmd_classify
  import ddr_mode_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic busy_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (!cke_i || cs_ni) cmd_o = CMD_NONE;
    else if (busy_i)     cmd_o = CMD_BLOCK;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MODE;
        default: cmd_o = CMD_BST;
      endcase
    end
  end
endmodule

// File: rtl/ddr_mode_check.sv
module ddr_mode_check
  import ddr_mode_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANKS  = 4
) (
  input  cmd_e              cmd_i,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANKS-1:0]  bank_open_i,
  output logic              wr_main_o,
  output logic              wr_ext_o,
  output logic              err_o
);
  // bits allowed to be nonzero in each register write
  localparam logic [ADDR_W-1:0] MAIN_KEEP = ADDR_W'(12'h17F);
  localparam logic [ADDR_W-1:0] EXT_KEEP  = ADDR_W'(12'h043);

  logic [BL_W-1:0] bl_code;
  logic [CL_W-1:0] cl_code;
  logic            is_mode, any_open, main_ok, ext_ok;

  assign bl_code  = addr_i[BL_LSB +: BL_W];
  assign cl_code  = addr_i[CL_LSB +: CL_W];
  assign is_mode  = (cmd_i == CMD_MODE);
  assign any_open = |bank_open_i;

  always_comb begin
    main_ok = !ba_i[1] && !ba_i[0] && !any_open
              && ((addr_i & ~MAIN_KEEP) == '0)
              && (bl_code inside {3'd1, 3'd2, 3'd3})
              && (cl_code inside {3'd3, 3'd4, 3'd5});
    ext_ok  = !ba_i[1] && ba_i[0] && !any_open
              && ((addr_i & ~EXT_KEEP) == '0);
  end

  assign wr_main_o = is_mode && main_ok;
  assign wr_ext_o  = is_mode && ext_ok;
  assign err_o     = is_mode && !main_ok && !ext_ok;
endmodule

// File: rtl/ddr_mode_regs.sv
module ddr_mode_regs
  import ddr_mode_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_main_i,
  input  logic              wr_ext_i,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [3:0]        burst_len_o,
  output logic              burst_il_o,
  output logic [2:0]        read_lat_o,
  output logic              dll_reset_o,
  output logic              dll_on_o,
  output logic [1:0]        drive_o,
  output logic              err_o,
  output logic              busy_o
);
  logic [BL_W-1:0] bl_q;
  logic [CL_W-1:0] cl_q;
  logic            il_q, dll_off_q, dllrst_q, err_q, busy_q;
  logic [1:0]      drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl_q      <= 3'd1;
      il_q      <= 1'b0;
      cl_q      <= 3'd3;
      dll_off_q <= 1'b0;
      drv_q     <= 2'b00;
      dllrst_q  <= 1'b0;
      err_q     <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      if (wr_main_i) begin
        bl_q <= addr_i[BL_LSB +: BL_W];
        il_q <= addr_i[IL_BIT];
        cl_q <= addr_i[CL_LSB +: CL_W];
      end
      if (wr_ext_i) begin
        dll_off_q <= addr_i[DLL_BIT];
        drv_q     <= {addr_i[DS1_BIT], addr_i[DS0_BIT]};
      end
      dllrst_q <= wr_main_i && addr_i[DR_BIT];
      err_q    <= err_i;
      busy_q   <= wr_main_i || wr_ext_i;
    end
  end

  // codes 1..3 map to 2,4,8; latency code equals latency
  assign burst_len_o = 4'(1) << bl_q;
  assign burst_il_o  = il_q;
  assign read_lat_o  = cl_q;
  assign dll_on_o    = !dll_off_q;
  assign drive_o     = drv_q;
  assign dll_reset_o = dllrst_q;
  assign err_o       = err_q;
  assign busy_o      = busy_q;

  p_err_keeps_regs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> ($stable(bl_q) && $stable(il_q) && $stable(cl_q)
               && $stable(dll_off_q) && $stable(drv_q)));
  p_err_no_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !busy_q);
  p_dll_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dllrst_q |=> !dllrst_q);
  p_dll_with_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dllrst_q |-> busy_q);
  p_busy_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !busy_q);
  p_len_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(burst_len_o) == 1 && !burst_len_o[0]);
  p_lat_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_lat_o >= 3'd3 && read_lat_o <= 3'd5);
endmodule

// File: rtl/ddr_mode_decoder.sv
module ddr_mode_decoder
  import ddr_mode_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANKS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANKS-1:0]  bank_open_i,
  output logic [3:0]        cmd_o,
  output logic [3:0]        burst_len_o,
  output logic              burst_il_o,
  output logic [2:0]        read_lat_o,
  output logic              dll_reset_o,
  output logic              dll_on_o,
  output logic [1:0]        drive_o,
  output logic              mode_err_o,
  output logic              busy_o
);
  cmd_e cmd_d, cmd_q;
  logic wr_main, wr_ext, err;

  ddr_cmd_classify u_cls (
    .cke_i  (cke_i),
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .busy_i (busy_o),
    .cmd_o  (cmd_d)
  );

  ddr_mode_check #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_chk (
    .cmd_i       (cmd_d),
    .ba_i        (ba_i),
    .addr_i      (addr_i),
    .bank_open_i (bank_open_i),
    .wr_main_o   (wr_main),
    .wr_ext_o    (wr_ext),
    .err_o       (err)
  );

  ddr_mode_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_main_i   (wr_main),
    .wr_ext_i    (wr_ext),
    .err_i       (err),
    .addr_i      (addr_i),
    .burst_len_o (burst_len_o),
    .burst_il_o  (burst_il_o),
    .read_lat_o  (read_lat_o),
    .dll_reset_o (dll_reset_o),
    .dll_on_o    (dll_on_o),
    .drive_o     (drive_o),
    .err_o       (mode_err_o),
    .busy_o      (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= CMD_NONE;
    else         cmd_q <= cmd_d;
  end
  assign cmd_o = cmd_q;

  p_err_is_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> cmd_q == CMD_MODE);
  p_busy_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (cmd_q != CMD_MODE && !mode_err_o && !busy_o));
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_NONE) |-> (!mode_err_o && !busy_o));
endmodule

// File: tb/ddr_mode_decoder_test.sv
module ddr_mode_decoder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cke_i = 1'b0, cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [1:0]  ba_i = '0;
  logic [11:0] addr_i = '0;
  logic [3:0]  bank_open_i = '0;
  logic [3:0]  cmd_o, burst_len_o;
  logic        burst_il_o, dll_reset_o, dll_on_o, mode_err_o, busy_o;
  logic [2:0]  read_lat_o;
  logic [1:0]  drive_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  int         m_bl = 2, m_cl = 3;
  logic       m_il = 0, m_dll = 1, m_busy = 0;
  logic [1:0] m_drv = 2'b00;

  logic [17:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  ddr_mode_decoder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni),
    .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i),
    .addr_i(addr_i), .bank_open_i(bank_open_i), .cmd_o(cmd_o),
    .burst_len_o(burst_len_o), .burst_il_o(burst_il_o), .read_lat_o(read_lat_o),
    .dll_reset_o(dll_reset_o), .dll_on_o(dll_on_o), .drive_o(drive_o),
    .mode_err_o(mode_err_o), .busy_o(busy_o)
  );

  function automatic logic [17:0] act_vec();
    return {cmd_o, burst_len_o, burst_il_o, read_lat_o, dll_reset_o,
            dll_on_o, drive_o, mode_err_o, busy_o};
  endfunction

  // driver: one call = one sampled edge
  task automatic drive(input logic cke, input logic cs, input logic [2:0] rcw,
                       input logic [1:0] ba, input logic [11:0] a,
                       input logic [3:0] open, input string tag);
    logic [3:0] c;
    logic err = 0, dr = 0, nb = 0, ok;
    @(negedge clk_i);
    cke_i = cke; cs_ni = cs; {ras_ni, cas_ni, we_ni} = rcw;
    ba_i = ba; addr_i = a; bank_open_i = open;
    if (!cke || cs) c = 4'd0;
    else if (m_busy) c = 4'd9;
    else case (rcw)
      3'b111: c = 4'd1; 3'b011: c = 4'd2; 3'b101: c = 4'd3; 3'b100: c = 4'd4;
      3'b010: c = 4'd5; 3'b001: c = 4'd6; 3'b000: c = 4'd7; default: c = 4'd8;
    endcase
    if (c == 4'd7) begin
      if (ba == 2'b00) begin
        ok = (a[2:0] >= 3'd1 && a[2:0] <= 3'd3) && (a[6:4] >= 3'd3 && a[6:4] <= 3'd5)
             && !a[7] && a[11:9] == 3'b000 && open == 4'h0;
        if (ok) begin
          m_bl = 1 << a[2:0]; m_il = a[3]; m_cl = int'(a[6:4]);
          dr = a[8]; nb = 1;
        end else err = 1;
      end else if (ba == 2'b01) begin
        ok = (a & ~12'h043) == 12'h000 && open == 4'h0;
        if (ok) begin m_dll = ~a[0]; m_drv = {a[6], a[1]}; nb = 1; end
        else err = 1;
      end else err = 1;
    end
    m_busy = nb;
    exp_q.push_back({c, 4'(m_bl), m_il, 3'(m_cl), dr, m_dll, m_drv, err, nb});
    tag_q.push_back(tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk_i); #2;
      if (exp_q.size() > 0) begin
        logic [17:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        n_chk++;
        if (act_vec() !== e) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", t, act_vec(), e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [2:0] NOP = 3'b111, MODE = 3'b000;

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    n_chk++;
    if (act_vec() !== {4'd0, 4'd2, 1'b0, 3'd3, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0}) begin
      n_bad++;
      $display("FAIL R1 reset actual=%h expected=%h", act_vec(),
               {4'd0, 4'd2, 1'b0, 3'd3, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0});
    end
    @(negedge clk_i); rst_ni = 1'b1;
    // R2 classification
    drive(1, 0, NOP,    2'b00, 12'h000, 4'h0, "R2 nop");
    drive(1, 0, 3'b011, 2'b10, 12'h123, 4'h0, "R2 act");
    drive(1, 0, 3'b101, 2'b00, 12'h000, 4'h1, "R2 read");
    drive(1, 0, 3'b100, 2'b00, 12'h000, 4'h1, "R2 write");
    drive(1, 0, 3'b010, 2'b00, 12'h400, 4'h1, "R2 pre");
    drive(1, 0, 3'b001, 2'b00, 12'h000, 4'h0, "R2 ref");
    drive(1, 0, 3'b110, 2'b00, 12'h000, 4'h0, "R2 bst");
    drive(0, 0, MODE,   2'b00, 12'h032, 4'h0, "R2 cke low");
    drive(1, 1, NOP,    2'b00, 12'h000, 4'h0, "R2 cs high");
    // R10 deselected mode write
    drive(1, 1, MODE,   2'b00, 12'h04B, 4'h0, "R10 cs high mode");
    drive(1, 0, NOP,    2'b00, 12'h000, 4'h0, "R10 after");
    // R3 R4 legal main writes: bl4 interleave cl4, then bl8 seq cl5
    drive(1, 0, MODE,   2'b00, 12'h04A, 4'h0, "R3 bl4 il cl4");
    drive(1, 0, NOP,    2'b00, 12'h000, 4'h0, "R9 busy nop");
    drive(1, 0, MODE,   2'b00, 12'h053, 4'h0, "R4 bl8 cl5");
    // R9 mode write in busy window is blocked
    drive(1, 0, MODE,   2'b00, 12'h031, 4'h0, "R9 blocked mode");
    drive(1, 0, 3'b011, 2'b00, 12'h000, 4'h0, "R9 act after");
    drive(1, 0, MODE,   2'b00, 12'h039, 4'h0, "R3 bl2 il cl3");
    drive(1, 0, 3'b011, 2'b00, 12'h000, 4'h0, "R9 blocked act");
    // R6 rejections, back to back
    drive(1, 0, MODE,   2'b00, 12'h040, 4'h0, "R6 bl 000");
    drive(1, 0, MODE,   2'b00, 12'h044, 4'h0, "R6 bl 100");
    drive(1, 0, MODE,   2'b00, 12'h022, 4'h0, "R6 cl 010");
    drive(1, 0, MODE,   2'b00, 12'h062, 4'h0, "R6 cl 110");
    drive(1, 0, MODE,   2'b00, 12'h0C2, 4'h0, "R6 a7 set");
    drive(1, 0, MODE,   2'b00, 12'h442, 4'h0, "R6 a10 set");
    drive(1, 0, MODE,   2'b10, 12'h042, 4'h0, "R6 ba1 main");
    drive(1, 0, MODE,   2'b11, 12'h001, 4'h0, "R6 ba1 ext");
    drive(1, 0, MODE,   2'b01, 12'h005, 4'h0, "R6 ext a2 set");
    drive(1, 0, MODE,   2'b01, 12'h801, 4'h0, "R6 ext a11 set");
    // R7 open bank
    drive(1, 0, MODE,   2'b00, 12'h042, 4'h8, "R7 bank3 open");
    drive(1, 0, MODE,   2'b01, 12'h043, 4'h1, "R7 ext bank0 open");
    // R5 extended writes
    drive(1, 0, MODE,   2'b01, 12'h043, 4'h0, "R5 dll off drv 11");
    drive(1, 0, NOP,    2'b00, 12'h000, 4'h0, "R9 busy after ext");
    drive(1, 0, MODE,   2'b01, 12'h040, 4'h0, "R5 dll on drv 10");
    drive(1, 0, NOP,    2'b00, 12'h000, 4'h0, "R5 hold");
    // R8 DLL reset with register update
    drive(1, 0, MODE,   2'b00, 12'h14A, 4'h0, "R8 dll reset");
    drive(1, 0, NOP,    2'b00, 12'h000, 4'h0, "R8 pulse ends");
    drive(1, 0, MODE,   2'b00, 12'h153, 4'h2, "R8 reset rejected open");
    drive(1, 0, MODE,   2'b00, 12'h033, 4'h0, "R3 legal after error");
    drive(1, 0, NOP,    2'b00, 12'h000, 4'h0, "R9 final");
    drive(1, 1, NOP,    2'b00, 12'h000, 4'h0, "R2 idle");
    repeat (3) @(posedge clk_i);
    #3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule